// File: doc/BRIEF.md
# Status-coded I2C bus master

This block is a single-master I2C controller that a processor steps through a transfer one phase at a time. The processor writes a few byte-wide registers to request a START, an address byte, data bytes or a STOP. The controller runs that phase on the two bus lines and then raises a completion flag. It reports what happened as an 8-bit status code and holds SCL low until software clears the flag. Clearing the flag starts the next phase, which is picked from the pending START and STOP requests and from the direction set by the address byte.

The bus rate comes from a two-field divider, an exponent N and a mantissa M. One SCL period lasts 10·(M+1)·2^(N+1) clock cycles. The bus outputs are line levels: 1 releases the open-drain line and 0 pulls it low. `sda_i` is the level seen on the data line.

Top module: `i2c_status_master`

## Requirements
- R1: After reset, and whenever the controller is idle, status (address 2) reads 0xF8, control (address 1) reads 0x00 after reset, and both `scl_o` and `sda_o` are 1.
- R2: A write to address 2 stores M in bits 6:3 and N in bits 2:0. One SCL period during a byte then lasts 10·(M+1)·2^(N+1) clock cycles.
- R3: With enable (control bit 6) and start (control bit 5) set, an idle controller produces a START condition, with SDA falling while SCL is high. It then sets the flag (control bit 3), sets status 0x08 and clears the start bit by itself.
- R4: While the flag is set, SCL stays low and the status does not change. Software can clear the flag by writing 0 to control bit 3, but writing 1 never sets it.
- R5: When the flag is cleared after a START, the byte in the data register (address 0) is sent MSB first as the address, and its bit 0 selects read (1) or write (0). The resulting status is 0x18 for write with ACK, 0x20 for write with NACK, 0x40 for read with ACK and 0x48 for read with NACK.
- R6: In write direction, clearing the flag sends the data register. The status becomes 0x28 if the receiver drove ACK (SDA low on the ninth clock) and 0x30 if it did not.
- R7: In read direction, clearing the flag clocks in one byte, which is then read back from the data register. The controller drives the ninth bit low when ack-enable (control bit 2) is set, giving status 0x50, and releases it when ack-enable is clear, giving status 0x58.
- R8: If start is set when the flag is cleared, a repeated START is produced without a STOP, ending in status 0x08.
- R9: If stop (control bit 4) is set and start is clear when the flag is cleared, a STOP condition is produced, with SDA rising while SCL is high. The controller then returns to idle with status 0xF8, stop and flag clear, and both lines at 1.
- R10: Any write to address 3 returns the controller at once to the idle state of R1, with control at 0x00, from any phase.
- R11: While enable is clear, a start request is ignored: the bus stays released and the status stays 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 data, 1 control, 2 status/divider, 3 soft reset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| scl_o | output | 1 | SCL line level driven (1 = released) |
| sda_o | output | 1 | SDA line level driven (1 = released) |
| sda_i | input | 1 | SDA line level observed |

## Verification
The bench uses the default build and sets five divider settings at run time: (M,N) = (0,0), (1,0), (0,2), (3,1) and (2,3). These cover SCL periods from 20 to 480 cycles and exercise both fields of the divider, including an exponent above 2. A behavioural target device on the lines answers ACK or NACK on request and returns bytes for reads. This lets every status code, the repeated START and the master's ACK level be observed from outside the block. Most transfers run at the fastest setting, so a mid-byte soft reset and the hold on SCL can be seen within a few hundred cycles.

// File: rtl/i2c_status_master.sv
module i2c_status_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       sda_i
);
  localparam int CW = 15;
  localparam logic [7:0] ST_IDLE = 8'hF8;

  typedef enum logic [3:0] {
    S_IDLE, S_ST0, S_ST1, S_ST2, S_LO, S_HI, S_HOLD, S_SP0, S_SP1, S_SP2
  } st_t;

  st_t        st;
  logic [7:0] data_q, shreg, status_q, code;
  logic [6:0] baud_q;
  logic       en, sta, sto, iflg, aak, rw_q, addr_ph, scl_q, sda_q;
  logic [3:0] bitn;
  logic [CW-1:0] cnt, half;
  logic       run, tick, tx, idle, ack_in;

  assign half   = (CW'(baud_q[6:3]) + CW'(1)) * CW'(10) << baud_q[2:0];
  assign idle   = (st == S_IDLE);
  assign run    = !(idle || st == S_HOLD);
  assign tick   = run && (cnt >= half - CW'(1));
  assign tx     = addr_ph | ~rw_q;
  assign ack_in = ~sda_i;
  assign scl_o  = scl_q;
  assign sda_o  = sda_q;

  always_comb begin
    if (addr_ph)   code = rw_q ? (ack_in ? 8'h40 : 8'h48) : (ack_in ? 8'h18 : 8'h20);
    else if (!rw_q) code = ack_in ? 8'h28 : 8'h30;
    else           code = sda_q ? 8'h58 : 8'h50;
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = data_q;
      2'd1:    rdata = {1'b0, en, sta, sto, iflg, aak, 2'b00};
      2'd2:    rdata = status_q;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; data_q <= '0; shreg <= '0; status_q <= ST_IDLE; baud_q <= '0;
      en <= 1'b0; sta <= 1'b0; sto <= 1'b0; iflg <= 1'b0; aak <= 1'b0;
      rw_q <= 1'b0; addr_ph <= 1'b0; scl_q <= 1'b1; sda_q <= 1'b1;
      bitn <= '0; cnt <= '0;
    end else if (wr_en && addr == 2'd3) begin
      st <= S_IDLE; data_q <= '0; shreg <= '0; status_q <= ST_IDLE; baud_q <= '0;
      en <= 1'b0; sta <= 1'b0; sto <= 1'b0; iflg <= 1'b0; aak <= 1'b0;
      rw_q <= 1'b0; addr_ph <= 1'b0; scl_q <= 1'b1; sda_q <= 1'b1;
      bitn <= '0; cnt <= '0;
    end else begin
      cnt <= (!run || tick) ? '0 : cnt + CW'(1);
      if (wr_en) begin
        case (addr)
          2'd0: data_q <= wdata;
          2'd1: begin
            en <= wdata[6]; sta <= wdata[5]; sto <= wdata[4]; aak <= wdata[2];
            if (!wdata[3]) iflg <= 1'b0;
          end
          default: baud_q <= wdata[6:0];
        endcase
      end
      case (st)
        S_IDLE: if (en && sta) st <= S_ST1;
        S_ST0:  if (tick) begin scl_q <= 1'b1; st <= S_ST1; end
        S_ST1:  if (tick) begin sda_q <= 1'b0; st <= S_ST2; end
        S_ST2:  if (tick) begin
          scl_q <= 1'b0; sta <= 1'b0; iflg <= 1'b1; status_q <= 8'h08;
          addr_ph <= 1'b1; st <= S_HOLD;
        end
        S_HOLD: if (!iflg) begin
          if (sta) begin sda_q <= 1'b1; st <= S_ST0; end
          else if (sto) begin sda_q <= 1'b0; st <= S_SP0; end
          else begin
            shreg <= data_q; bitn <= '0;
            if (addr_ph) rw_q <= data_q[0];
            st <= S_LO;
          end
        end
        S_LO: begin
          if (cnt == '0)
            sda_q <= (bitn == 4'd8) ? (tx ? 1'b1 : ~aak) : (tx ? shreg[7] : 1'b1);
          if (tick) begin scl_q <= 1'b1; st <= S_HI; end
        end
        S_HI: if (tick) begin
          scl_q <= 1'b0;
          shreg <= {shreg[6:0], sda_i};
          if (bitn == 4'd8) begin
            iflg <= 1'b1; status_q <= code; addr_ph <= 1'b0; st <= S_HOLD;
            if (!tx) data_q <= shreg;
          end else begin
            bitn <= bitn + 4'd1; st <= S_LO;
          end
        end
        S_SP0: if (tick) begin scl_q <= 1'b1; st <= S_SP1; end
        S_SP1: if (tick) begin sda_q <= 1'b1; st <= S_SP2; end
        S_SP2: if (tick) begin sto <= 1'b0; status_q <= ST_IDLE; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_status_master_chk.sv
module i2c_status_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic       scl_o,
  input logic       sda_o,
  input logic       iflg,
  input logic       en,
  input logic       idle,
  input logic [7:0] status_q
);
  a_r4_flag_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
    iflg |-> !scl_o);

  a_r4_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && $past(iflg)) |-> $stable(status_q));

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (scl_o && sda_o && status_q == 8'hF8));

  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3) |=> (idle && !iflg && status_q == 8'hF8));

  a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !en && !wr_en) |=> idle);
endmodule

bind i2c_status_master i2c_status_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .scl_o(scl_o),
  .sda_o(sda_o), .iflg(iflg), .en(en), .idle(idle), .status_q(status_q)
);

// File: tb/i2c_status_master_test.sv
module i2c_status_master_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic scl_o, sda_o, sda_i;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  i2c_status_master uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i));

  // behavioural target device
  logic drive = 1'b1, ps = 1'b1, pd = 1'b1;
  logic s_nack = 1'b0, s_rw = 1'b0, in_addr = 1'b0, s_sel = 1'b0, done_rd = 1'b0;
  logic m_ack_seen = 1'b0;
  logic [7:0] sh = 8'd0, got_addr = 8'd0, got_data = 8'd0, tx_byte = 8'd0;
  int bitc = 0;
  assign sda_i = sda_o & drive;

  always @(negedge clk) begin
    if (scl_o && ps && pd && !sda_o) begin
      bitc = 0; in_addr = 1'b1; s_sel = 1'b0; done_rd = 1'b0; drive = 1'b1;
    end else if (scl_o && ps && !pd && sda_o) begin
      bitc = 0; in_addr = 1'b0; s_sel = 1'b0; drive = 1'b1;
    end else if (scl_o && !ps) begin
      if (bitc < 8) sh = {sh[6:0], sda_i};
      else begin
        if (in_addr) begin got_addr = sh; s_rw = sh[0]; s_sel = !s_nack; end
        else if (!s_rw) got_data = sh;
        else begin m_ack_seen = !sda_i; if (sda_i) done_rd = 1'b1; end
        in_addr = 1'b0;
      end
      bitc = (bitc == 8) ? 0 : bitc + 1;
    end
    if (!scl_o) begin
      if (bitc == 8) drive = (in_addr || !s_rw) ? s_nack : 1'b1;
      else drive = (!in_addr && s_rw && s_sel && !done_rd) ? tx_byte[7-bitc] : 1'b1;
    end
    ps = scl_o; pd = sda_o;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_flag(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 30000; i++) begin
      rd(2'd1, v);
      if (v[3]) return;
    end
    chk({tag, " flag timeout"}, 0, 1);
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 30000; i++) begin
      rd(2'd2, v);
      if (v == 8'hF8) return;
    end
    chk({tag, " idle timeout"}, 0, 1);
  endtask

  task automatic status_is(input string tag, input logic [7:0] e);
    logic [7:0] v;
    rd(2'd2, v); chk(tag, v, e);
  endtask

  // {baud byte, SCL period in cycles}
  localparam logic [19:0] VEC [5] = '{
    {8'h00, 12'd20}, {8'h08, 12'd40}, {8'h02, 12'd80}, {8'h19, 12'd160}, {8'h13, 12'd480}
  };

  initial begin
    logic [7:0] v;
    int t0, cyc;
    logic pr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    status_is("R1 reset status", 8'hF8);
    rd(2'd1, v); chk("R1 reset control", v, 8'h00);
    chk("R1 reset scl", scl_o, 1); chk("R1 reset sda", sda_o, 1);
    // R4 flag cannot be set by software
    wr(2'd1, 8'h08); rd(2'd1, v); chk("R4 flag not settable", v[3], 0);
    // R11 start ignored while disabled
    wr(2'd1, 8'h20); repeat (100) @(negedge clk);
    status_is("R11 disabled status", 8'hF8); chk("R11 disabled scl", scl_o, 1);
    wr(2'd3, 8'h00);

    // R2 divider table
    for (int k = 0; k < 5; k++) begin
      s_nack = 1'b0;
      wr(2'd2, VEC[k][19:12]);
      wr(2'd1, 8'h60); wait_flag("R3");
      status_is("R3 start status", 8'h08);
      rd(2'd1, v); chk("R3 start bit cleared", v[5], 0);
      wr(2'd0, 8'hA4); wr(2'd1, 8'h40);
      pr = scl_o; t0 = -1; cyc = 0;
      for (int i = 0; i < 5000; i++) begin
        @(negedge clk); cyc++;
        if (scl_o && !pr) begin
          if (t0 < 0) t0 = cyc; else break;
        end
        pr = scl_o;
      end
      chk("R2 scl period", cyc - t0, VEC[k][11:0]);
      wait_flag("R5");
      status_is("R5 write addr ack", 8'h18);
      chk("R5 address byte on bus", got_addr, 8'hA4);
      wr(2'd1, 8'h50); wait_idle("R9");
      rd(2'd1, v); chk("R9 stop and flag cleared", v & 8'h18, 0);
      chk("R9 lines released", {scl_o, sda_o}, 2'b11);
    end
    wr(2'd2, 8'h00);

    // R4 hold, R6 write data
    wr(2'd1, 8'h60); wait_flag("R4");
    repeat (200) @(negedge clk);
    chk("R4 scl held low", scl_o, 0); status_is("R4 status held", 8'h08);
    wr(2'd0, 8'hA4); wr(2'd1, 8'h40); wait_flag("R5");
    status_is("R5 write addr ack", 8'h18);
    wr(2'd0, 8'h3C); wr(2'd1, 8'h40); wait_flag("R6");
    status_is("R6 data ack", 8'h28); chk("R6 data byte on bus", got_data, 8'h3C);
    s_nack = 1'b1;
    wr(2'd0, 8'h81); wr(2'd1, 8'h40); wait_flag("R6");
    status_is("R6 data nack", 8'h30);
    s_nack = 1'b0;
    // R8 repeated start then R7 reads
    wr(2'd1, 8'h60); wait_flag("R8");
    status_is("R8 repeated start", 8'h08);
    wr(2'd0, 8'hA5); wr(2'd1, 8'h40); wait_flag("R5");
    status_is("R5 read addr ack", 8'h40);
    tx_byte = 8'hC6;
    wr(2'd1, 8'h44); wait_flag("R7");
    status_is("R7 rx with ack", 8'h50);
    rd(2'd0, v); chk("R7 rx byte 1", v, 8'hC6); chk("R7 master ack low", m_ack_seen, 1);
    tx_byte = 8'h39;
    wr(2'd1, 8'h40); wait_flag("R7");
    status_is("R7 rx with nack", 8'h58);
    rd(2'd0, v); chk("R7 rx byte 2", v, 8'h39); chk("R7 master nack", m_ack_seen, 0);
    wr(2'd1, 8'h50); wait_idle("R9");
    chk("R9 lines released", {scl_o, sda_o}, 2'b11);

    // R5 address nacks
    s_nack = 1'b1;
    wr(2'd1, 8'h60); wait_flag("R3");
    wr(2'd0, 8'hA4); wr(2'd1, 8'h40); wait_flag("R5");
    status_is("R5 write addr nack", 8'h20);
    wr(2'd1, 8'h60); wait_flag("R8");
    wr(2'd0, 8'hA5); wr(2'd1, 8'h40); wait_flag("R5");
    status_is("R5 read addr nack", 8'h48);
    wr(2'd1, 8'h50); wait_idle("R9");
    s_nack = 1'b0;

    // R10 soft reset mid-byte
    wr(2'd1, 8'h60); wait_flag("R10");
    wr(2'd0, 8'h00); wr(2'd1, 8'h40);
    repeat (30) @(negedge clk);
    wr(2'd3, 8'h00);
    status_is("R10 status", 8'hF8);
    rd(2'd1, v); chk("R10 control", v, 8'h00);
    chk("R10 lines released", {scl_o, sda_o}, 2'b11);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule